// File: doc/BRIEF.md
# ECC Error Logger

This block sits beside the ECC checker of a DRAM controller and keeps a record of memory errors for software to poll. The checker raises a correctable or an uncorrectable strobe for one cycle. With the strobe it presents the 4 KiB block number of the failing access, the 8-bit syndrome and the channel. The block holds two sticky flags. It also holds one set of captured details, and that set always describes the most severe error still pending.

The capture rules are as follows:
- A correctable error is captured only when nothing is pending.
- An uncorrectable error replaces the details of a pending correctable error.
- Once an uncorrectable error is pending, no later error of either class changes the captured details.

Software reads the registers through a word-select port. It clears the flags by writing ones to them. An enable register chooses which error classes produce a one-cycle system-error pulse.

The register map is:

| Select | Register | Contents |
|---|---|---|
| 0 | status | bit 0 is the correctable flag and bit 7 is the uncorrectable flag |
| 1 | address | block number in bits 31:12 |
| 2 | syndrome | syndrome in bits 7:0 |
| 3 | detail | channel in bit 0 |
| 4 | command | bit 7 and bit 8 are the pulse enables |

All other bits and all other selects read as zero.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every register select reads zero and `serr_pulse` is low.
- R2: A correctable strobe sets status bit 0, and an uncorrectable strobe sets status bit 7. A strobe wins over a same-cycle write-one-to-clear of its own flag, so the flag stays set.
- R3: A write to select 0 clears each flag whose data bit (0 or 7) is 1. Zero bits leave the flags as they are. All other status bits always read zero.
- R4: A correctable strobe with no flag set captures the error details:
  - select 1 returns the block number in bits 31:12, with bits 11:0 zero;
  - select 2 returns the syndrome in bits 7:0;
  - select 3 returns the channel in bit 0, with bits 7:1 zero.
- R5: A correctable strobe while the correctable flag is set leaves the captured address, syndrome and channel unchanged.
- R6: An uncorrectable strobe while the uncorrectable flag is clear captures its details, overwriting any correctable capture. When both strobes arrive in the same cycle, the uncorrectable details are the ones kept.
- R7: While the uncorrectable flag is set, strobes of either class leave the captured details unchanged.
- R8: Select 4 stores bit 7 as the correctable pulse enable and bit 8 as the uncorrectable pulse enable. Its other bits read zero.
- R9: `serr_pulse` is high for exactly the one cycle after the edge where an enabled flag went from 0 to 1. A strobe for a flag that is already set, or whose class is disabled, gives no pulse.
- R10: Selects 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_strobe | input | 1 | Correctable error detected this cycle |
| ue_strobe | input | 1 | Uncorrectable error detected this cycle |
| err_blk | input | 20 | 4 KiB block number of the failing access |
| err_syn | input | 8 | ECC syndrome |
| err_chan | input | 1 | Channel of the failing access |
| reg_sel | input | 3 | Register select |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| serr_pulse | output | 1 | One-cycle system-error pulse |

## Verification
The assertions assume that the strobes are synchronous single-cycle events. They also assume that the error details are valid whenever either strobe is high, because both classes share one set of detail inputs. The stimulus drives the strobes, the details and the register writes only between clock edges, for one cycle at a time. It returns the strobes to zero after each event. So every captured value can be traced to exactly one edge. The collision cases are deliberate: both strobes together, and a strobe together with a clear. They are created by raising both inputs in the same cycle.

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int BLK_W = 20,
  parameter int SYN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_strobe,
  input  logic             ue_strobe,
  input  logic [BLK_W-1:0] err_blk,
  input  logic [SYN_W-1:0] err_syn,
  input  logic             err_chan,
  input  logic [2:0]       reg_sel,
  input  logic             reg_we,
  input  logic [15:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             serr_pulse
);
  localparam int LOW_W = 32 - BLK_W;

  logic             ce_q, ue_q, en_ce_q, en_ue_q, chan_q, serr_q;
  logic [BLK_W-1:0] blk_q;
  logic [SYN_W-1:0] syn_q;

  wire wr_stat = reg_we && (reg_sel == 3'd0);
  wire wr_cmd  = reg_we && (reg_sel == 3'd4);
  wire cap     = (ue_strobe && !ue_q) || (ce_strobe && !ce_q && !ue_q);
  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[15:9], reg_wdata[6:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q    <= 1'b0;
      ue_q    <= 1'b0;
      en_ce_q <= 1'b0;
      en_ue_q <= 1'b0;
      chan_q  <= 1'b0;
      blk_q   <= '0;
      syn_q   <= '0;
      serr_q  <= 1'b0;
    end else begin
      ce_q   <= ce_strobe | (ce_q & ~(wr_stat & reg_wdata[0]));
      ue_q   <= ue_strobe | (ue_q & ~(wr_stat & reg_wdata[7]));
      serr_q <= (ce_strobe & ~ce_q & en_ce_q) | (ue_strobe & ~ue_q & en_ue_q);
      if (cap) begin
        blk_q  <= err_blk;
        syn_q  <= err_syn;
        chan_q <= err_chan;
      end
      if (wr_cmd) begin
        en_ce_q <= reg_wdata[7];
        en_ue_q <= reg_wdata[8];
      end
    end
  end

  always_comb begin
    case (reg_sel)
      3'd0:    reg_rdata = {24'h0, ue_q, 6'h0, ce_q};
      3'd1:    reg_rdata = {blk_q, {LOW_W{1'b0}}};
      3'd2:    reg_rdata = {{(32-SYN_W){1'b0}}, syn_q};
      3'd3:    reg_rdata = {31'h0, chan_q};
      3'd4:    reg_rdata = {23'h0, en_ue_q, en_ce_q, 7'h0};
      default: reg_rdata = 32'h0;
    endcase
  end

  assign serr_pulse = serr_q;

  assert_ce_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_strobe |=> ce_q);
  assert_ue_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ue_strobe |=> ue_q);
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[0] && !ce_strobe) |=> !ce_q);
  assert_ce_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_q && !ue_strobe) |=> ($stable(blk_q) && $stable(syn_q) && $stable(chan_q)));
  assert_ue_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_strobe && !ue_q) |=> (blk_q == $past(err_blk) && syn_q == $past(err_syn)
                              && chan_q == $past(err_chan)));
  assert_ue_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ue_q |=> ($stable(blk_q) && $stable(syn_q) && $stable(chan_q)));
  assert_serr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_strobe && !ue_strobe) |=> !serr_pulse);
endmodule

// File: tb/ecc_err_log_bench.sv
module ecc_err_log_bench;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, ce = 0, ue = 0, chan = 0, we = 0;
  logic [19:0] blk = '0;
  logic [7:0]  syn = '0;
  logic [2:0]  sel = '0;
  logic [15:0] wdata = '0;
  logic [31:0] rdata;
  logic        serr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  ecc_err_log u_ecc_err_log (
    .clk(clk), .rst_n(rst_n), .ce_strobe(ce), .ue_strobe(ue), .err_blk(blk),
    .err_syn(syn), .err_chan(chan), .reg_sel(sel), .reg_we(we),
    .reg_wdata(wdata), .reg_rdata(rdata), .serr_pulse(serr));

  typedef struct packed {
    logic ce; logic ue; logic [19:0] blk; logic [7:0] syn; logic chan;
    logic [15:0] stat; logic [19:0] eblk; logic [7:0] esyn; logic echan;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 1'b0, 20'h12345, 8'h5A, 1'b1, 16'h0001, 20'h12345, 8'h5A, 1'b1},
    '{1'b1, 1'b0, 20'h0AAAA, 8'h33, 1'b0, 16'h0001, 20'h12345, 8'h5A, 1'b1},
    '{1'b0, 1'b1, 20'hFEDCB, 8'h99, 1'b0, 16'h0081, 20'hFEDCB, 8'h99, 1'b0},
    '{1'b0, 1'b1, 20'h11111, 8'h01, 1'b1, 16'h0081, 20'hFEDCB, 8'h99, 1'b0},
    '{1'b1, 1'b0, 20'h22222, 8'h44, 1'b1, 16'h0081, 20'hFEDCB, 8'h99, 1'b0},
    '{1'b0, 1'b0, 20'h33333, 8'h55, 1'b0, 16'h0081, 20'hFEDCB, 8'h99, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    sel = s; #1; v = rdata;
  endtask

  task automatic cyc(input logic c, input logic u, input logic [19:0] b, input logic [7:0] sy,
                     input logic ch, input logic w, input logic [2:0] s, input logic [15:0] d);
    ce = c; ue = u; blk = b; syn = sy; chan = ch; we = w; sel = s; wdata = d;
    @(posedge clk); @(negedge clk);
    ce = 0; ue = 0; we = 0;
  endtask

  task automatic expect_regs(input string req, input logic [15:0] st, input logic [19:0] b,
                             input logic [7:0] sy, input logic ch);
    logic [31:0] v;
    rd(3'd0, v); check({req, " status"}, v, {16'h0, st});
    rd(3'd1, v); check({req, " address"}, v, {b, 12'h0});
    rd(3'd2, v); check({req, " syndrome"}, v, {24'h0, sy});
    rd(3'd3, v); check({req, " detail"}, v, {31'h0, ch});
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 and R10: all registers zero after reset
    for (int i = 0; i < 8; i++) begin
      rd(i[2:0], v); check("R1/R10 reset read", v, 32'h0);
    end
    check("R1 serr reset", {31'h0, serr}, 32'h0);

    // Vector walk: R2, R4, R5, R6, R7
    for (int i = 0; i < 6; i++) begin
      cyc(VEC[i].ce, VEC[i].ue, VEC[i].blk, VEC[i].syn, VEC[i].chan, 1'b0, 3'd0, 16'h0);
      expect_regs("R4/R5/R6/R7 vector", VEC[i].stat, VEC[i].eblk, VEC[i].esyn, VEC[i].echan);
    end

    // R3: zero bits ignored, reserved bits read zero, clear both
    cyc(0, 0, 0, 0, 0, 1, 3'd0, 16'hFF7E);
    rd(3'd0, v); check("R3 zero bits no effect", v, 32'h0081);
    cyc(0, 0, 0, 0, 0, 1, 3'd0, 16'h0081);
    expect_regs("R3 clear keeps details", 16'h0000, 20'hFEDCB, 8'h99, 1'b0);

    // R6: both strobes in one cycle
    cyc(1, 1, 20'h0BEEF, 8'h7E, 1, 0, 3'd0, 16'h0);
    expect_regs("R6 simultaneous", 16'h0081, 20'h0BEEF, 8'h7E, 1'b1);

    // R3: clear correctable only, R7: CE with UE pending does not capture
    cyc(0, 0, 0, 0, 0, 1, 3'd0, 16'h0001);
    rd(3'd0, v); check("R3 clear CE only", v, 32'h0080);
    cyc(1, 0, 20'h44444, 8'h12, 0, 0, 3'd0, 16'h0);
    expect_regs("R7 CE under UE", 16'h0081, 20'h0BEEF, 8'h7E, 1'b1);

    // R2: strobe beats same-cycle clear
    cyc(1, 0, 20'h55555, 8'h66, 0, 1, 3'd0, 16'h0081);
    rd(3'd0, v); check("R2 strobe beats clear", v, 32'h0001);
    cyc(0, 0, 0, 0, 0, 1, 3'd0, 16'h0081);
    cyc(1, 0, 20'h66666, 8'h21, 0, 0, 3'd0, 16'h0);
    expect_regs("R4 fresh CE", 16'h0001, 20'h66666, 8'h21, 1'b0);
    // R6: UE overwrites pending CE details
    cyc(0, 1, 20'h77777, 8'hE1, 1, 0, 3'd0, 16'h0);
    expect_regs("R6 UE over CE", 16'h0081, 20'h77777, 8'hE1, 1'b1);

    // R8: command register bits
    cyc(0, 0, 0, 0, 0, 1, 3'd4, 16'hFFFF);
    rd(3'd4, v); check("R8 command readback", v, 32'h0000_0180);

    // R9: pulse behaviour
    cyc(0, 0, 0, 0, 0, 1, 3'd0, 16'h0081);
    check("R9 no pulse on clear", {31'h0, serr}, 32'h0);
    cyc(1, 0, 20'h1, 8'h1, 0, 0, 3'd0, 16'h0);
    check("R9 CE pulse high", {31'h0, serr}, 32'h1);
    @(negedge clk);
    check("R9 pulse one cycle", {31'h0, serr}, 32'h0);
    cyc(1, 0, 20'h2, 8'h2, 0, 0, 3'd0, 16'h0);
    check("R9 no pulse flag already set", {31'h0, serr}, 32'h0);
    cyc(0, 1, 20'h3, 8'h3, 0, 0, 3'd0, 16'h0);
    check("R9 UE pulse high", {31'h0, serr}, 32'h1);
    cyc(0, 0, 0, 0, 0, 1, 3'd4, 16'h0100);
    rd(3'd4, v); check("R8 UE enable only", v, 32'h0000_0100);
    cyc(0, 0, 0, 0, 0, 1, 3'd0, 16'h0081);
    cyc(1, 0, 20'h4, 8'h4, 0, 0, 3'd0, 16'h0);
    check("R9 CE disabled no pulse", {31'h0, serr}, 32'h0);
    cyc(0, 1, 20'h5, 8'h5, 1, 0, 3'd0, 16'h0);
    check("R9 UE enabled pulse", {31'h0, serr}, 32'h1);
    rd(3'd5, v); check("R10 unused select", v, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule